// File: doc/BRIEF.md
# Parallel Memory Command Timing Sequencer

This block runs single accesses to an external parallel memory of PC Card or NAND type. After it accepts a request, each access goes through three timed phases. First an address setup phase, then a command phase in which the write or read strobe is held low, then a hold phase in which the address and the write data stay on the pins. The length of each phase comes from a 32-bit timing word. The block has one timing word for the common space and one for the attribute space. A request selects the word it uses.

The attribute space is eight bits wide, so a wider request to it becomes a run of single-byte accesses at consecutive addresses. Read bytes are packed into the result word. During a write, the data bus stays undriven for a programmable number of cycles from the start of each access. An external active-low wait pin can stretch the command phase past its programmed length. The pin is sampled only when the programmed command time has run out. A `done` pulse marks the last hold cycle of the request.

Top module: `pmem_seq`

## Requirements
- R1: After reset, `busy` and `mem_doe` are low and both `mem_we_n` and `mem_oe_n` are high.
- R2: Setup runs for the timing word's bits 7:0 plus 1 cycles for a PC Card request (`req_nand`=0), and plus 2 for NAND (`req_nand`=1). The count starts at the first `busy` cycle, or at the end of the previous hold phase, and ends when the strobe falls. Code 0xFF therefore gives 256 or 257 cycles.
- R3: The strobe stays low for at least the wait field (bits 15:8) plus 1 cycles. A wait code of 0 behaves as 1, which gives 2 cycles.
- R4: `mem_wait_n` passes through two flops. When the minimum command time has run out and the synchronised wait is low, the strobe stays low. The strobe is released after the first cycle in which the synchronised value is high. If the pin goes high in strobe cycle j (counting from 0), the strobe lasts max(W, j+2)+1 cycles, where W is the wait code with 0 taken as 1.
- R5: After release, the hold phase lasts the hold field (bits 23:16) in cycles, with code 0 taken as 1. `done` is high only in the last hold cycle of the last access.
- R6: On a write, `mem_doe` stays low for the first Z cycles of each access, where Z is bits 31:24, and is high for the rest of that access. On a read, `mem_doe` never goes high.
- R7: An attribute request (`req_attr`=1) with `req_size` 0, 1 or 2 runs 1, 2 or 4 byte accesses. Access k uses address `req_addr`+k and drives write byte k (bits 8k+7:8k) on `mem_dout[7:0]`, with the upper bits at zero. A common-space request runs one access at the full width, on `req_addr`, with the whole write word.
- R8: The attribute timing word is used when `req_attr`=1, or when `req_nand`=1 and `req_last`=1. All other requests use the common word.
- R9: Read data is captured on the clock edge that releases the strobe. A common read returns the whole `mem_din`. Attribute read k returns `mem_din[7:0]` in `rdata` byte k, with unused bytes at zero. `rdata` is 0 after a write.
- R10: A request is accepted only while `busy` is low. A `req_valid` while busy causes no extra access and does not change the running one. `mem_we_n` and `mem_oe_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_attr | input | 1 | 1 = attribute space, 0 = common space |
| req_nand | input | 1 | 1 = NAND device, 0 = PC Card |
| req_last | input | 1 | NAND final address cycle, selects attribute timing |
| req_size | input | SW | Attribute byte count code (1 << code bytes) |
| req_addr | input | AW | Start address |
| req_wdata | input | DW | Write data |
| tim_common | input | 32 | Common-space timing word |
| tim_attr | input | 32 | Attribute-space timing word |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Last hold cycle of the request |
| rdata | output | DW | Collected read data |
| mem_addr | output | AW | Memory address |
| mem_dout | output | DW | Memory write data |
| mem_doe | output | 1 | Data bus output enable |
| mem_din | input | DW | Memory read data |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_wait_n | input | 1 | Wait from the memory, active low |

## Verification
The hardest case to reach is the wait extension. The pin only matters at the end of the programmed command time, and it reaches the state machine two cycles after it changes. The bench holds `mem_wait_n` low before it issues the request. It then counts strobe-low cycles at the ports and releases the pin at a known cycle j, so the expected strobe length is max(W, j+2)+1. The reserved zero codes, a 257-cycle NAND setup, the NAND last-address timing choice and a request issued while busy are each driven by a dedicated request.

// File: rtl/pmem_pkg.sv
// Shared types for the parallel memory sequencer.
// The timing word layout is fixed: HiZ, hold, wait and setup, from the top byte down.
package pmem_pkg;
    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_CMD, PH_HOLD} phase_t;

    typedef struct packed {
        logic [7:0] hiz;
        logic [7:0] hold;
        logic [7:0] wt;
        logic [7:0] setup;
    } tword_t;

    localparam logic [31:0] ATTR_TWORD_RST = 32'hFCFC_FCFC;
endpackage

// File: rtl/pmem_wait_sync.sv
// Two-flop synchroniser for the active-low wait pin.
// Assumes the pin is asynchronous to clk. Resets to the not-waiting level.
module pmem_wait_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_n_i,
    output logic wait_ok_o
);
    logic s1;

    // shift the pin through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1        <= 1'b1;
            wait_ok_o <= 1'b1;
        end else begin
            s1        <= wait_n_i;
            wait_ok_o <= s1;
        end
    end
endmodule

// File: rtl/pmem_timing_pick.sv
// Decodes one timing word into counter preloads.
// A reserved zero in the wait or hold field is read as 1.
// NAND adds one more setup cycle than PC Card.
module pmem_timing_pick
    import pmem_pkg::*;
(
    input  logic [31:0] word_i,
    input  logic        nand_i,
    output logic [8:0]  setup_m1_o,
    output logic [7:0]  wait_cnt_o,
    output logic [7:0]  hold_m1_o,
    output logic [7:0]  hiz_o
);
    tword_t tw;

    // split the word and turn each field into a preload
    always_comb begin
        tw         = tword_t'(word_i);
        setup_m1_o = {1'b0, tw.setup} + {8'd0, nand_i};
        wait_cnt_o = (tw.wt == 8'd0) ? 8'd1 : tw.wt;
        hold_m1_o  = (tw.hold == 8'd0) ? 8'd0 : tw.hold - 8'd1;
        hiz_o      = tw.hiz;
    end
endmodule

// File: rtl/pmem_phase_ctl.sv
// Phase state machine for a single access: setup, command, then hold.
// The command phase is stretched while the synchronised wait is low
// once the programmed count has run out.
// start_i in the last hold cycle chains straight into the next access.
module pmem_phase_ctl
    import pmem_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [8:0] setup_m1_i,
    input  logic [7:0] wait_cnt_i,
    input  logic [7:0] hold_m1_i,
    input  logic       wait_ok_i,
    output phase_t     phase_o,
    output logic       cmd_release_o,
    output logic       hold_end_o
);
    logic [8:0] cnt;

    // step through the phases with one shared down-counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_o <= PH_IDLE;
            cnt     <= '0;
        end else begin
            unique case (phase_o)
                PH_IDLE: if (start_i) begin
                    phase_o <= PH_SETUP;
                    cnt     <= setup_m1_i;
                end
                PH_SETUP: if (cnt == 9'd0) begin
                    phase_o <= PH_CMD;
                    cnt     <= {1'b0, wait_cnt_i};
                end else begin
                    cnt <= cnt - 9'd1;
                end
                PH_CMD: if (cnt != 9'd0) begin
                    cnt <= cnt - 9'd1;
                end else if (wait_ok_i) begin
                    phase_o <= PH_HOLD;
                    cnt     <= {1'b0, hold_m1_i};
                end
                PH_HOLD: if (cnt != 9'd0) begin
                    cnt <= cnt - 9'd1;
                end else if (start_i) begin
                    phase_o <= PH_SETUP;
                    cnt     <= setup_m1_i;
                end else begin
                    phase_o <= PH_IDLE;
                end
                default: phase_o <= PH_IDLE;
            endcase
        end
    end

    // phase boundary strobes for the datapath
    assign cmd_release_o = (phase_o == PH_CMD) && (cnt == 9'd0) && wait_ok_i;
    assign hold_end_o    = (phase_o == PH_HOLD) && (cnt == 9'd0);

    // R3
    cmd_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_CMD && cnt != 9'd0) |=> (phase_o == PH_CMD));
    // R4
    wait_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_CMD && cnt == 9'd0 && !wait_ok_i) |=> (phase_o == PH_CMD));
    // R5
    hold_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_HOLD && cnt != 9'd0) |=> (phase_o == PH_HOLD));
endmodule

// File: rtl/pmem_seq.sv
// Top level of the sequencer. Latches a request, picks the timing word,
// splits attribute requests into byte accesses, and drives the memory pins.
// Assumes DW is a multiple of 8 and at least 16. Timing inputs are held
// steady while busy is high.
module pmem_seq
    import pmem_pkg::*;
#(
    parameter  int AW  = 16,
    parameter  int DW  = 32,
    localparam int NB  = DW / 8,
    localparam int LGB = $clog2(NB),
    localparam int SW  = $clog2(LGB + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_attr,
    input  logic          req_nand,
    input  logic          req_last,
    input  logic [SW-1:0] req_size,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [31:0]   tim_common,
    input  logic [31:0]   tim_attr,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dout,
    output logic          mem_doe,
    input  logic [DW-1:0] mem_din,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    input  logic          mem_wait_n
);
    phase_t          phase;
    logic            wait_ok, cmd_release, hold_end, accept, start, last_beat;
    logic            op_write, op_attr, op_nand;
    logic [31:0]     tim_q, sel_word;
    logic [AW-1:0]   addr_q;
    logic [DW-1:0]   wdata_q, rdata_q;
    logic [LGB-1:0]  beat, last_idx;
    logic [7:0]      hiz_cnt, hiz_ld, wait_cnt, hold_m1;
    logic [8:0]      setup_m1;
    logic [SW-1:0]   size_c;
    logic [LGB:0]    span;

    assign busy      = (phase != PH_IDLE);
    assign accept    = req_valid && !busy;
    assign last_beat = (beat == last_idx);
    assign start     = accept || (hold_end && !last_beat);

    // timing word: taken from the request when idle, from the latch when busy
    assign sel_word = busy ? tim_q
                    : ((req_attr || (req_nand && req_last)) ? tim_attr : tim_common);

    // limit the size code to the data width, then count the bytes
    always_comb begin
        size_c = (req_size > SW'(LGB)) ? SW'(LGB) : req_size;
        span   = (LGB+1)'(1) << size_c;
    end

    pmem_wait_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_n_i  (mem_wait_n),
        .wait_ok_o (wait_ok)
    );

    pmem_timing_pick u_pick (
        .word_i     (sel_word),
        .nand_i     (busy ? op_nand : req_nand),
        .setup_m1_o (setup_m1),
        .wait_cnt_o (wait_cnt),
        .hold_m1_o  (hold_m1),
        .hiz_o      (hiz_ld)
    );

    pmem_phase_ctl u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .setup_m1_i    (setup_m1),
        .wait_cnt_i    (wait_cnt),
        .hold_m1_i     (hold_m1),
        .wait_ok_i     (wait_ok),
        .phase_o       (phase),
        .cmd_release_o (cmd_release),
        .hold_end_o    (hold_end)
    );

    // latch the request and step the byte index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_write <= 1'b0;
            op_attr  <= 1'b0;
            op_nand  <= 1'b0;
            tim_q    <= ATTR_TWORD_RST;
            addr_q   <= '0;
            wdata_q  <= '0;
            beat     <= '0;
            last_idx <= '0;
        end else if (accept) begin
            op_write <= req_write;
            op_attr  <= req_attr;
            op_nand  <= req_nand;
            tim_q    <= sel_word;
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
            beat     <= '0;
            last_idx <= req_attr ? LGB'(span - (LGB+1)'(1)) : '0;
        end else if (hold_end && !last_beat) begin
            beat <= beat + LGB'(1);
        end
    end

    // capture read data on the edge that releases the strobe
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            rdata_q <= '0;
        end else if (cmd_release && !op_write) begin
            if (op_attr) rdata_q[8*beat +: 8] <= mem_din[7:0];
            else         rdata_q <= mem_din;
        end
    end

    // count down the bus HiZ window from the start of each access
    always_ff @(posedge clk) begin
        if (!rst_n)              hiz_cnt <= '0;
        else if (start)          hiz_cnt <= hiz_ld;
        else if (hiz_cnt != 8'd0) hiz_cnt <= hiz_cnt - 8'd1;
    end

    // memory pin drive
    assign mem_addr = addr_q + AW'(beat);
    assign mem_dout = op_attr ? DW'(wdata_q[8*beat +: 8]) : wdata_q;
    assign mem_doe  = op_write && busy && (hiz_cnt == 8'd0);
    assign mem_we_n = !((phase == PH_CMD) && op_write);
    assign mem_oe_n = !((phase == PH_CMD) && !op_write);
    assign done     = hold_end && last_beat;
    assign rdata    = rdata_q;

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));
    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> ($stable(addr_q) && $stable(op_write)));
    // R6
    read_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_doe);
    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: tb/pmem_seq_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task queues the expected strobe pulses and
// request ends. A negedge monitor measures the pins and compares them with the queue.
module pmem_seq_bench;
    typedef struct {
        bit          is_end;
        int          pre;
        int          len;
        logic [15:0] addr;
        bit          we;
        logic [31:0] dout;
        int          hiz;
        logic [31:0] rdata;
    } exp_t;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0, req_attr = 0, req_nand = 0, req_last = 0;
    logic [1:0]  req_size = 0;
    logic [15:0] req_addr = 0;
    logic [31:0] req_wdata = 0, tim_common = 0, tim_attr = 0;
    logic        busy, done, mem_doe, mem_we_n, mem_oe_n;
    logic        mem_wait_n = 1'b1;
    logic [31:0] rdata, mem_dout, mem_din;
    logic [15:0] mem_addr;

    int   n_chk = 0, n_fail = 0, cyc = 0;
    bit   finished = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    // the memory model returns a pattern built from the address
    function automatic logic [31:0] model(input logic [15:0] a);
        logic [7:0] b = a[7:0];
        return {~b, b + 8'd3, b ^ 8'h3C, b};
    endfunction
    assign mem_din = model(mem_addr);

    pmem_seq u_pmem_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_attr(req_attr), .req_nand(req_nand), .req_last(req_last),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .tim_common(tim_common), .tim_attr(tim_attr), .busy(busy), .done(done),
        .rdata(rdata), .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe),
        .mem_din(mem_din), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_wait_n(mem_wait_n)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: queue the expected results, then run one request
    task automatic do_req(input bit w, input bit at, input bit nd, input bit lst,
                          input logic [1:0] sz, input logic [15:0] ad,
                          input logic [31:0] wd, input int ext, input bit poke);
        logic [31:0] word, rexp;
        int s, wc, l, h, z, n, per;
        exp_t e;
        word = (at || (nd && lst)) ? tim_attr : tim_common;          // R8
        s  = int'(word[7:0]) + 1 + int'(nd);                         // R2
        wc = (word[15:8] == 0) ? 1 : int'(word[15:8]);               // R3
        l  = (ext >= 0 && ext + 2 > wc) ? ext + 3 : wc + 1;          // R4
        h  = (word[23:16] == 0) ? 1 : int'(word[23:16]);             // R5
        z  = int'(word[31:24]);
        n  = at ? (1 << sz) : 1;                                     // R7
        per = s + l + h;
        rexp = '0;
        for (int k = 0; k < n; k++) begin
            e = '{is_end: 0, pre: (k == 0) ? s : h + s, len: l, addr: ad + 16'(k),
                  we: w, dout: at ? {24'd0, wd[8*k +: 8]} : wd, hiz: 0, rdata: 0};
            q.push_back(e);
            if (at) rexp[8*k +: 8] = model(ad + 16'(k)) & 32'hFF;
        end
        if (!at) rexp = model(ad);
        e = '{is_end: 1, pre: 0, len: h, addr: ad, we: w, dout: 0,
              hiz: w ? n * ((z < per) ? z : per) : 0, rdata: w ? 32'd0 : rexp};
        q.push_back(e);
        if (ext >= 0) mem_wait_n = 1'b0;
        @(negedge clk);
        {req_write, req_attr, req_nand, req_last} = {w, at, nd, lst};
        req_size = sz; req_addr = ad; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            req_valid = 1'b1; req_addr = 16'h7777; req_write = ~w;
            @(negedge clk);
            req_valid = 1'b0;
        end
        if (ext >= 0) begin
            while (mem_we_n && mem_oe_n) @(negedge clk);
            repeat (ext) @(negedge clk);
            mem_wait_n = 1'b1;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: measure pulses and request ends at the pins
    int   gap = 0, plen = 0, hz_lo = 0, hz_hi = 0;
    bit   prev_low = 0;
    int   f_pre;
    logic [15:0] f_addr;
    bit   f_we;
    logic [31:0] f_dout;
    always @(negedge clk) begin
        exp_t e;
        bit low;
        if (rst_n && !finished) begin
            low = !mem_we_n || !mem_oe_n;
            if (busy) begin
                if (!mem_doe) hz_lo++; else hz_hi++;
                if (low) begin
                    if (!prev_low) begin
                        f_pre = gap; f_addr = mem_addr; f_we = !mem_we_n;
                        f_dout = mem_dout; plen = 0;
                    end
                    plen++;
                end else begin
                    if (prev_low) begin
                        if (q.size() == 0 || q[0].is_end) begin
                            check(0, "R10 unexpected access", f_addr, 0);
                        end else begin
                            e = q.pop_front();
                            check(f_pre == e.pre, "R2 setup/gap", f_pre, e.pre);
                            check(plen == e.len, "R3 R4 strobe length", plen, e.len);
                            check(f_addr == e.addr, "R7 address", f_addr, e.addr);
                            check(f_we == e.we, "R10 strobe kind", f_we, e.we);
                            if (e.we) check(f_dout == e.dout, "R7 write data", f_dout, e.dout);
                        end
                        gap = 0;
                    end
                    gap++;
                end
                if (done) begin
                    if (q.size() == 0 || !q[0].is_end) begin
                        check(0, "R5 unexpected done", 1, 0);
                    end else begin
                        e = q.pop_front();
                        check(gap == e.len, "R5 hold length", gap, e.len);
                        if (e.we) check(hz_lo == e.hiz, "R6 HiZ cycles", hz_lo, e.hiz);
                        else      check(hz_hi == 0, "R6 read drive cycles", hz_hi, 0);
                        check(rdata == e.rdata, "R9 read data", rdata, e.rdata);
                    end
                    gap = 0; hz_lo = 0; hz_hi = 0;
                end
            end
            prev_low = low;
        end
    end

    // watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy, "R1 busy", busy, 0);
        check(!mem_doe, "R1 doe", mem_doe, 0);
        check(mem_we_n && mem_oe_n, "R1 strobes", {mem_we_n, mem_oe_n}, 3);
        // PC Card common write
        tim_common = {8'd2, 8'd3, 8'd2, 8'd1};
        do_req(1, 0, 0, 0, 2'd0, 16'h0100, 32'hDEADBEEF, -1, 0);
        // NAND common read with reserved wait and hold codes (R3, R5)
        tim_common = {8'd9, 8'd0, 8'd0, 8'd0};
        do_req(0, 0, 1, 0, 2'd0, 16'h0040, 32'h0, -1, 0);
        // attribute write split into four bytes (R7)
        tim_attr = {8'd1, 8'd2, 8'd1, 8'd3};
        do_req(1, 1, 0, 0, 2'd2, 16'h0200, 32'h44332211, -1, 0);
        // attribute read split into two bytes (R9)
        do_req(0, 1, 0, 0, 2'd1, 16'h0310, 32'h0, -1, 0);
        // R8: NAND last address cycle takes the attribute word
        tim_common = {8'd0, 8'd5, 8'd5, 8'd5};
        tim_attr   = {8'd3, 8'd1, 8'd1, 8'd0};
        do_req(1, 0, 1, 1, 2'd0, 16'h0055, 32'h000000A7, -1, 0);
        // R4: wait pin held low, released in strobe cycle 6
        tim_common = {8'd0, 8'd1, 8'd2, 8'd0};
        do_req(0, 0, 0, 0, 2'd0, 16'h0420, 32'h0, 6, 0);
        // R10: request while busy is ignored
        tim_common = {8'd0, 8'd2, 8'd1, 8'd1};
        do_req(1, 0, 0, 0, 2'd0, 16'h0500, 32'h12345678, -1, 1);
        // R2: longest NAND setup, 257 cycles
        tim_common = {8'd0, 8'd1, 8'd1, 8'hFF};
        do_req(0, 0, 1, 0, 2'd0, 16'h0600, 32'h0, -1, 0);
        // attribute byte write with the attribute reset pattern
        tim_attr = 32'hFCFCFCFC;
        do_req(1, 1, 0, 0, 2'd0, 16'h0700, 32'h000000C3, -1, 0);
        repeat (5) @(negedge clk);
        // R10: no queued result left over and no extra one
        check(q.size() == 0, "R10 leftover expected items", q.size(), 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule